// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller gathers a bank of interrupt request lines, each with a software-set enable bit and a 2-bit priority level, where level 3 is the most urgent. From the enabled pending lines it picks one winner. It then tests the winner against the core's 2-bit interrupt mask and against the level already in service. A winner that passes raises a request to the core, together with its vector number and a handler address.

The handler address is usually the vector base plus two words per vector. Two fast match slots can override it. When the winning vector equals a slot's programmed vector and the winner runs at level 2, the slot's own full handler address is presented instead, and a fast flag is raised. This decision is made inside the controller, before the core takes the request.

An acknowledge from the core pushes the level in service onto a small stack and raises the in-service code. A return strobe pops the stack and restores the previous code.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, cur_lvl_o is 00, all sources are disabled, and every configuration register reads as zero.
- R2: The winner is the enabled pending source with the highest priority, and ties go to the lowest source index. The priority of source s is bits [2*(s%8)+1:2*(s%8)] of the register at address s/8. The enable of source s is bit s%16 of the register at address 8+s/16. Disabled sources never win. The vector number is the source index.
- R3: The winner is requested only when its priority p satisfies p >= core_mask_i. Mask 00 admits levels 0-3, 01 admits 1-3, 10 admits 2-3 and 11 admits 3 only.
- R4: The winner is requested only when p >= cur_lvl_o. An acknowledge of a level-p request sets cur_lvl_o to p+1, saturating at 3.
- R5: Each acknowledge saves the previous code on a stack. A return restores the most recently saved code. A return with an empty stack leaves cur_lvl_o at 00.
- R6: While DEPTH codes are saved, irq_o stays 0 for every request.
- R7: The normal handler address is {vector base, 8'h00} + 2*vector. The vector base is written at address 16.
- R8: Fast match slot k holds a vector number at address 17+k, a low handler address half at 19+2k and a high 8-bit half at 20+2k. A request raises fast_o and presents {high, low} when its vector matches a slot and its priority is 2.
- R9: A match at any priority other than 2 is handled as a normal vector, with fast_o at 0.
- R10: When both slots match, slot 0's address is used.
- R11: irq_o, vec_o, vaddr_o and fast_o follow the request and mask inputs in the same cycle, and they read zero whenever irq_o is 0. Writes, acknowledges and returns take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | NUM_SRC | Level-sensitive request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Register write data |
| core_mask_i | input | 2 | Core interrupt mask |
| ack_i | input | 1 | Core accepts the presented request |
| ret_i | input | 1 | Core returns from the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 7 | Winning vector number |
| vaddr_o | output | 24 | Handler address |
| fast_o | output | 1 | Fast handler selected |
| cur_lvl_o | output | 2 | In-service level code |

## Verification
The request path is purely combinational, so irq_o, vec_o, vaddr_o and fast_o are due in the same cycle that a request pattern or mask is applied. The bench drives these inputs on a falling edge and samples 1 ns later, still inside that cycle. Register writes, acknowledges and returns register at the next rising edge. For these, the bench holds the strobe across exactly one rising edge, drops it on the following falling edge, and only then samples cur_lvl_o or the affected address. In this way every check reads a value that has settled one register stage after its cause.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW     = 16;
  localparam int AW     = 24;
  localparam int RW     = 5;
  localparam int VEC_W  = 7;
  localparam int NSLOT  = 2;

  localparam int A_PRIO = 0;
  localparam int A_EN   = 8;
  localparam int A_VBA  = 16;
  localparam int A_FM   = 17;
  localparam int A_FA   = 19;

  typedef logic [1:0] lvl_t;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [RW-1:0]                wr_addr_i,
  input  logic [DW-1:0]                wr_data_i,
  output logic [2*NUM_SRC-1:0]         prio_o,
  output logic [NUM_SRC-1:0]           en_o,
  output logic [DW-1:0]                vba_o,
  output logic [NSLOT-1:0][VEC_W-1:0]  fm_o,
  output logic [NSLOT-1:0][AW-1:0]     fa_o
);
  localparam int NPW = NUM_SRC / 8;
  localparam int NEW = NUM_SRC / 16;
  localparam int HW  = AW - DW;

  for (genvar w = 0; w < NPW; w++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_o[w*DW +: DW] <= '0;
      else if (wr_en_i && wr_addr_i == RW'(A_PRIO + w)) prio_o[w*DW +: DW] <= wr_data_i;
    end
  end

  for (genvar w = 0; w < NEW; w++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_o[w*DW +: DW] <= '0;
      else if (wr_en_i && wr_addr_i == RW'(A_EN + w)) en_o[w*DW +: DW] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vba_o <= '0;
    else if (wr_en_i && wr_addr_i == RW'(A_VBA)) vba_o <= wr_data_i;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fm_o[s] <= '0;
        fa_o[s] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == RW'(A_FM + s))       fm_o[s] <= wr_data_i[VEC_W-1:0];
        if (wr_addr_i == RW'(A_FA + 2*s))     fa_o[s][DW-1:0] <= wr_data_i;
        if (wr_addr_i == RW'(A_FA + 2*s + 1)) fa_o[s][AW-1:DW] <= wr_data_i[HW-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   req_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic [2*NUM_SRC-1:0] prio_i,
  output logic                 win_v_o,
  output logic [IW-1:0]        win_idx_o,
  output lvl_t                 win_lvl_o
);
  // descending scan with >= leaves the lowest index among equal levels
  always_comb begin
    win_v_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && en_i[i] && (!win_v_o || prio_i[2*i +: 2] >= win_lvl_o)) begin
        win_v_o   = 1'b1;
        win_idx_o = IW'(i);
        win_lvl_o = prio_i[2*i +: 2];
      end
    end
  end

  p_win_real_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_v_o |-> (req_i[win_idx_o] && en_i[win_idx_o]));
  p_win_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_v_o |-> ((req_i & en_i) == '0));
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t push_lvl_i,
  output lvl_t cur_o,
  output logic full_o
);
  lvl_t          stk_q [DEPTH];
  logic [CW-1:0] cnt_q;
  lvl_t          cur_q;
  logic          empty;

  assign empty  = (cnt_q == '0);
  assign full_o = (cnt_q == CW'(DEPTH));
  assign cur_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && !full_o) begin
      stk_q[IW'(cnt_q)] <= cur_q;
      cur_q             <= push_lvl_i;
      cnt_q             <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      cur_q <= stk_q[IW'(cnt_q - 1'b1)];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_push_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_empty_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> cur_q == '0);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(cur_q));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DEPTH   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               wr_en_i,
  input  logic [RW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [1:0]         core_mask_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [AW-1:0]      vaddr_o,
  output logic               fast_o,
  output logic [1:0]         cur_lvl_o
);
  localparam int IW = $clog2(NUM_SRC);
  localparam lvl_t FAST_LVL = 2'd2;

  logic [2*NUM_SRC-1:0]        prio;
  logic [NUM_SRC-1:0]          en;
  logic [DW-1:0]               vba;
  logic [NSLOT-1:0][VEC_W-1:0] fm;
  logic [NSLOT-1:0][AW-1:0]    fa;
  logic                        win_v;
  logic [IW-1:0]               win_idx;
  lvl_t                        win_lvl, cur_lvl, next_lvl;
  logic                        full, allowed, push, pop;
  logic [VEC_W-1:0]            win_vec;
  logic [NSLOT-1:0]            hit;
  logic [AW-1:0]               norm_addr, fast_addr;

  pic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .prio_o(prio), .en_o(en), .vba_o(vba), .fm_o(fm), .fa_o(fa)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i, .rst_ni, .req_i(irq_req_i), .en_i(en), .prio_i(prio),
    .win_v_o(win_v), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  pic_level_stack #(.DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .push_lvl_i(next_lvl),
    .cur_o(cur_lvl), .full_o(full)
  );

  assign win_vec  = VEC_W'(win_idx);
  assign allowed  = win_v && (win_lvl >= lvl_t'(core_mask_i)) && (win_lvl >= cur_lvl) && !full;
  assign next_lvl = (win_lvl == 2'd3) ? 2'd3 : win_lvl + 2'd1;
  assign push     = ack_i && allowed;
  assign pop      = ret_i && !push;

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign hit[s] = (fm[s] == win_vec);
  end

  assign norm_addr = {vba, {(AW-DW){1'b0}}} + AW'({win_vec, 1'b0});

  // lower slot index wins on a double match
  always_comb begin
    fast_addr = '0;
    for (int s = NSLOT - 1; s >= 0; s--) if (hit[s]) fast_addr = fa[s];
  end

  logic is_fast;
  assign is_fast   = allowed && (win_lvl == FAST_LVL) && (|hit);
  assign irq_o     = allowed;
  assign vec_o     = allowed ? win_vec : '0;
  assign fast_o    = is_fast;
  assign vaddr_o   = !allowed ? '0 : (is_fast ? fast_addr : norm_addr);
  assign cur_lvl_o = cur_lvl;

  p_ack_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (cur_lvl_o > $past(cur_lvl_o)) || ($past(cur_lvl_o) == 2'd3));
  p_fast_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> (irq_o && (vec_o == fm[0] || vec_o == fm[1])));
  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vaddr_o == '0 && !fast_o));
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] req = '0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mask = '0;
  logic        ack = 0, ret = 0;
  logic        irq, fast;
  logic [6:0]  vec;
  logic [23:0] vaddr;
  logic [1:0]  cur;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .core_mask_i(mask), .ack_i(ack), .ret_i(ret),
    .irq_o(irq), .vec_o(vec), .vaddr_o(vaddr), .fast_o(fast), .cur_lvl_o(cur)
  );

  typedef struct packed {
    logic [15:0] req;
    logic [1:0]  mask;
    logic        irq;
    logic [6:0]  vec;
    logic [23:0] addr;
    logic        fast;
  } row_t;

  localparam row_t TBL [12] = '{
    '{16'h0001, 2'd0, 1'b1, 7'd0, 24'h012000, 1'b0},  // R7 level 0
    '{16'h0003, 2'd0, 1'b1, 7'd1, 24'h012002, 1'b0},  // R2 higher level
    '{16'h0003, 2'd2, 1'b0, 7'd0, 24'h000000, 1'b0},  // R3 masked
    '{16'h0010, 2'd0, 1'b1, 7'd4, 24'hAABEEF, 1'b1},  // R8 slot 0
    '{16'h0020, 2'd2, 1'b1, 7'd5, 24'h551234, 1'b1},  // R8 slot 1
    '{16'h0030, 2'd0, 1'b1, 7'd4, 24'hAABEEF, 1'b1},  // R2 tie
    '{16'h0038, 2'd3, 1'b1, 7'd3, 24'h012006, 1'b0},  // R3 level 3
    '{16'h8000, 2'd0, 1'b0, 7'd0, 24'h000000, 1'b0},  // R2 disabled
    '{16'h0300, 2'd0, 1'b1, 7'd8, 24'h012010, 1'b0},  // R2 upper word
    '{16'h00C0, 2'd1, 1'b1, 7'd6, 24'h01200C, 1'b0},  // R3 mask 01
    '{16'h0080, 2'd1, 1'b0, 7'd0, 24'h000000, 1'b0},  // R3 blocks 0
    '{16'h0000, 2'd0, 1'b0, 7'd0, 24'h000000, 1'b0}   // R11 idle
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic apply(logic [15:0] r, logic [1:0] m);
    @(negedge clk); req = r; mask = m; #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; #1;
  endtask

  task automatic pulse_ret();
    @(negedge clk); ret = 1;
    @(negedge clk); ret = 0; #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1;
    req = 16'h0001; #1;
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 level after reset", 32'(cur), 0);
    chk("R1 addr after reset", 32'(vaddr), 0);
    req = '0;

    wr(5'd0, 16'h1AE4);   // s0..s7 = 0,1,2,3,2,2,1,0
    wr(5'd1, 16'h5555);   // s8..s15 = 1
    wr(5'd8, 16'h7FFF);   // s15 disabled
    wr(5'd16, 16'h0120);
    wr(5'd17, 16'd4);
    wr(5'd18, 16'd5);
    wr(5'd19, 16'hBEEF);
    wr(5'd20, 16'h00AA);
    wr(5'd21, 16'h1234);
    wr(5'd22, 16'h0055);

    for (int i = 0; i < 12; i++) begin
      apply(TBL[i].req, TBL[i].mask);
      chk($sformatf("R2/R3/R7/R8 row%0d irq", i), 32'(irq), 32'(TBL[i].irq));
      chk($sformatf("R2 row%0d vec", i), 32'(vec), 32'(TBL[i].vec));
      chk($sformatf("R7/R8 row%0d addr", i), 32'(vaddr), 32'(TBL[i].addr));
      chk($sformatf("R8 row%0d fast", i), 32'(fast), 32'(TBL[i].fast));
    end

    // nesting and stack
    apply(16'h0002, 2'd0);
    pulse_ack();
    chk("R4 level after p1 ack", 32'(cur), 2);
    chk("R4 same level blocked", 32'(irq), 0);
    apply(16'h0012, 2'd0);
    chk("R4 p2 nests", 32'(vec), 4);
    pulse_ack();
    chk("R4 level after p2 ack", 32'(cur), 3);
    apply(16'h0008, 2'd0);
    chk("R4 p3 nests over code 3", 32'(irq), 1);
    pulse_ack();
    chk("R4 level saturates", 32'(cur), 3);
    pulse_ack();
    #1 chk("R6 full stack blocks", 32'(irq), 0);
    req = '0;
    pulse_ret(); chk("R5 pop1", 32'(cur), 3);
    pulse_ret(); chk("R5 pop2", 32'(cur), 3);
    pulse_ret(); chk("R5 pop3", 32'(cur), 2);
    pulse_ret(); chk("R5 pop4", 32'(cur), 0);
    pulse_ret(); chk("R5 empty return", 32'(cur), 0);
    apply(16'h0001, 2'd0);
    chk("R5 base level accepts p0", 32'(irq), 1);

    // fast slot corner cases
    wr(5'd17, 16'd3);
    apply(16'h0008, 2'd0);
    chk("R9 match at level 3 fast", 32'(fast), 0);
    chk("R9 match at level 3 addr", 32'(vaddr), 32'h012006);
    wr(5'd17, 16'd4);
    wr(5'd18, 16'd4);
    apply(16'h0010, 2'd0);
    chk("R10 slot0 precedence addr", 32'(vaddr), 32'hAABEEF);
    chk("R10 fast", 32'(fast), 1);

    wr(5'd16, 16'h0200);
    apply(16'h0200, 2'd0);
    chk("R7 new base", 32'(vaddr), 32'h020012);
    chk("R11 irq same cycle", 32'(irq), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule